// File: doc/BRIEF.md
# Buffered Compare PWM Output Channel Pair

This block turns shared timebase counts into two PWM output levels. Each of its two channels picks one of three 16-bit timebases with its own selector. It compares the picked count with an active compare value and changes its output level when the two agree. A change is only considered in a cycle where the picked timebase reports a tick, meaning the count advanced. A pair-wide mode chooses the change rule. Two modes are edge-driven: toggle on every match, or a set/clear pair in which channel 0's match raises the even output and channel 1's match lowers it. The other two modes are level-driven and produce center-aligned waveforms from an up/down count, with the output high (or low) while the count is above the compare value.

Each channel has a shadow buffer in front of its compare register. Software may load the shadow at any moment. The active value is then replaced only at the timebase's zero or peak event, whichever is chosen, so a period in flight is never cut short. With the buffer off, a write lands in the active register directly. A disabled channel outputs a software-chosen level. Each channel also raises a one-cycle match interrupt.

Top module: `cmp_pwm_pair`

## Requirements
- R1: After reset both outputs and both interrupts are low and both active compare values are 0, so a tick with count 0 on an enabled channel is a match.
- R2: Selector code 0, 1 or 2 (bits [1:0] for channel 0, bits [3:2] for channel 1) connects timebase 0, 1 or 2 to the channel; code 3 connects none, so the channel never matches, never transfers, and its level holds.
- R3: match_irq[i] is high for exactly the one cycle after a cycle in which channel i is enabled, its timebase ticks, and the count equals its active compare value; otherwise it is low.
- R4: A disabled channel outputs its force bit one cycle later and raises no interrupt.
- R5: Mode 0 (toggle): an enabled output inverts one cycle after each match and holds otherwise.
- R6: Mode 1 (set/clear): output 0 goes high after a channel-0 match and low after a channel-1 match, with the clear winning if both come in the same cycle; output 1 toggles on its own match.
- R7: Mode 2 (active-high): on every tick of its timebase an enabled output becomes 1 when the count is greater than the compare value and 0 otherwise, for rising and falling counts alike; without a tick it holds.
- R8: Mode 3 (active-low): like mode 2 with the output level inverted.
- R9: With the buffer off, a write replaces the active compare value and is in effect from the next cycle.
- R10: With the buffer on, a write only loads the shadow; the active value keeps its old content until a transfer event.
- R11: The transfer event is a tick with the zero flag when xfer_peak[i] is 0 and a tick with the peak flag when it is 1; the other flag does not transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_cnt | input | 48 | Three timebase counts, timebase t at bits [16t+15:16t] |
| tb_tick | input | 3 | Timebase t advanced this cycle |
| tb_zero | input | 3 | Timebase t count is at zero |
| tb_peak | input | 3 | Timebase t count is at its peak |
| pair_mode | input | 2 | Change rule: 0 toggle, 1 set/clear, 2 active-high, 3 active-low |
| ch_en | input | 2 | Per-channel compare enable |
| ch_sel | input | 4 | Per-channel timebase selector, 2 bits each |
| ch_force | input | 2 | Output level while the channel is disabled |
| buf_en | input | 2 | Per-channel shadow buffer enable |
| xfer_peak | input | 2 | Transfer at peak (1) or at zero (0) |
| wr_en | input | 2 | Per-channel compare write strobe |
| wr_data | input | 16 | Compare write value |
| pwm_out | output | 2 | PWM output levels |
| match_irq | output | 2 | Per-channel match interrupt pulse |

## Verification
A wrong active compare value shows at match_irq within one tick of the count reaching either the expected or the stored value, and the exhaustive level-mode sweeps expose it on pwm_out at the first count that crosses it. A transfer at the wrong event shows as an interrupt at the old value after the intended transfer point, or at the new value before it. A lost toggle or set/clear state inverts pwm_out from the next match onward, so the sweeps over several periods catch it within one period.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

  typedef enum logic [1:0] {
    MODE_UP_TOGGLE = 2'd0,
    MODE_UP_SETCLR = 2'd1,
    MODE_UD_HIGH   = 2'd2,
    MODE_UD_LOW    = 2'd3
  } cpp_mode_e;

  typedef struct packed {
    logic tick;
    logic zero;
    logic peak;
  } cpp_evt_t;

endpackage

// File: rtl/cpp_tb_mux.sv
module cpp_tb_mux
  import cpp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_TB = 3,
  parameter int SEL_W  = 2
) (
  input  logic [NUM_TB*CNT_W-1:0] tb_cnt_i,
  input  logic [NUM_TB-1:0]       tb_tick_i,
  input  logic [NUM_TB-1:0]       tb_zero_i,
  input  logic [NUM_TB-1:0]       tb_peak_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [CNT_W-1:0]        cnt_o,
  output cpp_evt_t                evt_o
);

  // Codes beyond the last timebase pick nothing: no tick, no events.
  always_comb begin
    cnt_o = '0;
    evt_o = '0;
    for (int t = 0; t < NUM_TB; t++) begin
      if (int'(sel_i) == t) begin
        cnt_o      = tb_cnt_i[t*CNT_W +: CNT_W];
        evt_o.tick = tb_tick_i[t];
        evt_o.zero = tb_zero_i[t];
        evt_o.peak = tb_peak_i[t];
      end
    end
  end

endmodule

// File: rtl/cpp_cmp_store.sv
module cpp_cmp_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             buf_en_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] act_o
);

  logic [CNT_W-1:0] shd_q, shd_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             shd_ce, act_ce;

  always_comb begin
    shd_ce = wr_en_i & buf_en_i;
    shd_d  = wr_data_i;
    act_ce = buf_en_i ? xfer_i : wr_en_i;
    act_d  = buf_en_i ? shd_q  : wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
    end else if (shd_ce) begin
      shd_q <= shd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_ce) begin
      act_q <= act_d;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/cpp_out_ctl.sv
module cpp_out_ctl
  import cpp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic [1:0] en_i,
  input  logic [1:0] force_i,
  input  logic [1:0] hit_i,
  input  logic [1:0] tick_i,
  input  logic [1:0] gt_i,
  output logic [1:0] out_o
);

  cpp_mode_e  mode;
  logic [1:0] out_q, out_d;
  logic [1:0] out_ce;

  always_comb begin
    mode = cpp_mode_e'(mode_i);
    for (int c = 0; c < 2; c++) begin
      if (!en_i[c]) begin
        out_d[c] = force_i[c];
      end else begin
        unique case (mode)
          MODE_UP_TOGGLE: out_d[c] = out_q[c] ^ hit_i[c];
          MODE_UP_SETCLR: begin
            if (c == 0) begin
              if (hit_i[1])      out_d[c] = 1'b0;
              else if (hit_i[0]) out_d[c] = 1'b1;
              else               out_d[c] = out_q[c];
            end else begin
              out_d[c] = out_q[c] ^ hit_i[c];
            end
          end
          MODE_UD_HIGH:   out_d[c] = tick_i[c] ?  gt_i[c] : out_q[c];
          MODE_UD_LOW:    out_d[c] = tick_i[c] ? ~gt_i[c] : out_q[c];
          default:        out_d[c] = out_q[c];
        endcase
      end
      out_ce[c] = out_d[c] ^ out_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (out_ce[c]) out_q[c] <= out_d[c];
      end
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/cmp_pwm_pair.sv
module cmp_pwm_pair
  import cpp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_TB = 3,
  localparam int SEL_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1,
  localparam int NCH   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_TB*CNT_W-1:0] tb_cnt,
  input  logic [NUM_TB-1:0]       tb_tick,
  input  logic [NUM_TB-1:0]       tb_zero,
  input  logic [NUM_TB-1:0]       tb_peak,
  input  logic [1:0]              pair_mode,
  input  logic [NCH-1:0]          ch_en,
  input  logic [NCH*SEL_W-1:0]    ch_sel,
  input  logic [NCH-1:0]          ch_force,
  input  logic [NCH-1:0]          buf_en,
  input  logic [NCH-1:0]          xfer_peak,
  input  logic [NCH-1:0]          wr_en,
  input  logic [CNT_W-1:0]        wr_data,
  output logic [NCH-1:0]          pwm_out,
  output logic [NCH-1:0]          match_irq
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_q_n = rst_sync_q[1];

  logic [NCH-1:0][CNT_W-1:0] sel_cnt;
  logic [NCH-1:0][CNT_W-1:0] act_cmp;
  logic [NCH-1:0]            sel_tick;
  logic [NCH-1:0]            hit;
  logic [NCH-1:0]            gt;
  logic [NCH-1:0]            xfer;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cpp_evt_t evt;

    cpp_tb_mux #(
      .CNT_W (CNT_W),
      .NUM_TB(NUM_TB),
      .SEL_W (SEL_W)
    ) u_mux (
      .tb_cnt_i (tb_cnt),
      .tb_tick_i(tb_tick),
      .tb_zero_i(tb_zero),
      .tb_peak_i(tb_peak),
      .sel_i    (ch_sel[g*SEL_W +: SEL_W]),
      .cnt_o    (sel_cnt[g]),
      .evt_o    (evt)
    );

    always_comb begin
      sel_tick[g] = evt.tick;
      hit[g]      = ch_en[g] & evt.tick & (sel_cnt[g] == act_cmp[g]);
      gt[g]       = sel_cnt[g] > act_cmp[g];
      xfer[g]     = buf_en[g] & evt.tick & (xfer_peak[g] ? evt.peak : evt.zero);
    end

    cpp_cmp_store #(
      .CNT_W(CNT_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .wr_en_i  (wr_en[g]),
      .wr_data_i(wr_data),
      .buf_en_i (buf_en[g]),
      .xfer_i   (xfer[g]),
      .act_o    (act_cmp[g])
    );
  end

  cpp_out_ctl u_out (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .mode_i (pair_mode),
    .en_i   (ch_en),
    .force_i(ch_force),
    .hit_i  (hit),
    .tick_i (sel_tick),
    .gt_i   (gt),
    .out_o  (pwm_out)
  );

  logic [NCH-1:0] irq_q, irq_d;

  always_comb irq_d = hit;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign match_irq = irq_q;

endmodule

// File: rtl/cpp_chk.sv
module cpp_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_TB = 3
) (
  input logic                      clk,
  input logic                      rst_q_n,
  input logic [1:0]                pair_mode,
  input logic [1:0]                ch_en,
  input logic [1:0]                ch_force,
  input logic [1:0]                buf_en,
  input logic [1:0]                wr_en,
  input logic [CNT_W-1:0]          wr_data,
  input logic [1:0]                pwm_out,
  input logic [1:0]                match_irq,
  input logic [1:0][CNT_W-1:0]     act_cmp,
  input logic [1:0][CNT_W-1:0]     sel_cnt,
  input logic [1:0]                sel_tick
);

  for (genvar i = 0; i < 2; i++) begin : g_a
    AST_DIS_FORCE: assert property (@(posedge clk) disable iff (!rst_q_n)
      !ch_en[i] |=> pwm_out[i] == $past(ch_force[i])); // R4

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_q_n)
      match_irq[i] |-> $past(ch_en[i] && sel_tick[i])); // R3

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ch_en[i] && pair_mode != 2'd1 && !sel_tick[i]) |=> $stable(pwm_out[i])); // R7

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en[i] && !buf_en[i]) |=> act_cmp[i] == $past(wr_data)); // R9

    AST_BUF_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
      (buf_en[i] && !sel_tick[i]) |=> $stable(act_cmp[i])); // R10

    AST_HIGH_LEVEL: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ch_en[i] && pair_mode == 2'd2 && sel_tick[i])
        |=> pwm_out[i] == $past(sel_cnt[i] > act_cmp[i])); // R7

    AST_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ch_en[i] && pair_mode == 2'd3 && sel_tick[i])
        |=> pwm_out[i] == $past(sel_cnt[i] <= act_cmp[i])); // R8
  end

endmodule

bind cmp_pwm_pair cpp_chk #(.CNT_W(CNT_W), .NUM_TB(NUM_TB)) u_cpp_chk (.*);

// File: tb/test_cmp_pwm_pair.sv
module test_cmp_pwm_pair;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] tb_cnt;
  logic [2:0]  tb_tick, tb_zero, tb_peak;
  logic [1:0]  pair_mode;
  logic [1:0]  ch_en, ch_force, buf_en, xfer_peak, wr_en;
  logic [3:0]  ch_sel;
  logic [15:0] wr_data;
  logic [1:0]  pwm_out, match_irq;

  int checks = 0;
  int errors = 0;
  bit exp0, exp1;

  always #4 clk = ~clk;

  cmp_pwm_pair i_cmp_pwm_pair (
    .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .tb_tick(tb_tick),
    .tb_zero(tb_zero), .tb_peak(tb_peak), .pair_mode(pair_mode),
    .ch_en(ch_en), .ch_sel(ch_sel), .ch_force(ch_force), .buf_en(buf_en),
    .xfer_peak(xfer_peak), .wr_en(wr_en), .wr_data(wr_data),
    .pwm_out(pwm_out), .match_irq(match_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, sample shortly after the rising edge.
  task automatic step(input int c0, input int c1, input int c2,
                      input logic [2:0] tk, input logic [2:0] zr, input logic [2:0] pk);
    @(negedge clk);
    tb_cnt  = {c2[15:0], c1[15:0], c0[15:0]};
    tb_tick = tk; tb_zero = zr; tb_peak = pk;
    @(posedge clk); #2;
    tb_tick = '0; tb_zero = '0; tb_peak = '0;
  endtask

  task automatic wr(input int ch, input int val);
    @(negedge clk);
    wr_en[ch] = 1'b1; wr_data = val[15:0];
    @(posedge clk); #2;
    wr_en = '0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; tb_cnt = '0; tb_tick = '0; tb_zero = '0; tb_peak = '0;
    pair_mode = 2'd0; ch_en = '0; ch_sel = '0; ch_force = '0; buf_en = '0;
    xfer_peak = '0; wr_en = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm_out == 2'b00, "R1 outputs after reset", pwm_out, 0);
    chk(match_irq == 2'b00, "R1 irq after reset", match_irq, 0);

    // R1: compare resets to 0; toggle mode on channel 0, timebase 0
    ch_en = 2'b01;
    step(0, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq == 2'b01, "R1 reset compare matches count 0", match_irq, 1);
    chk(pwm_out[0] == 1'b1, "R5 toggle on first match", pwm_out[0], 1);
    exp0 = 1'b1;

    // R9: direct write takes effect next cycle
    wr(0, 5);
    step(5, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b1, "R9 direct write in effect", match_irq[0], 1);
    exp0 = ~exp0;
    chk(pwm_out[0] == exp0, "R5 toggle", pwm_out[0], exp0);

    // R5 and R3: sawtooth sweep over three periods
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 8; c++) begin
        step(c, 0, 0, 3'b001, 3'b000, 3'b000);
        if (c == 5) exp0 = ~exp0;
        chk(pwm_out[0] == exp0, "R5 sweep level", pwm_out[0], exp0);
        chk(match_irq[0] == (c == 5), "R3 irq on match only", match_irq[0], (c == 5));
        chk(pwm_out[1] == 1'b0, "R4 disabled channel at force 0", pwm_out[1], 0);
      end
    end

    // R3: matching count without a tick does nothing
    step(5, 0, 0, 3'b000, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b0, "R3 no tick no irq", match_irq[0], 0);
    chk(pwm_out[0] == exp0, "R3 no tick level holds", pwm_out[0], exp0);

    // R2: selector
    ch_sel[1:0] = 2'd2;
    step(5, 5, 0, 3'b111, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b0, "R2 unselected timebase ignored", match_irq[0], 0);
    step(0, 0, 5, 3'b111, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b1, "R2 selected timebase 2 matches", match_irq[0], 1);
    exp0 = ~exp0;
    chk(pwm_out[0] == exp0, "R2 level follows timebase 2", pwm_out[0], exp0);
    ch_sel[1:0] = 2'd3;
    step(5, 5, 5, 3'b111, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b0, "R2 code 3 never matches", match_irq[0], 0);
    chk(pwm_out[0] == exp0, "R2 code 3 level holds", pwm_out[0], exp0);
    ch_sel[1:0] = 2'd0;

    // R4: disabled channel drives force bit
    ch_en[0] = 1'b0; ch_force[0] = 1'b1;
    step(5, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(pwm_out[0] == 1'b1, "R4 force 1", pwm_out[0], 1);
    chk(match_irq[0] == 1'b0, "R4 no irq while disabled", match_irq[0], 0);
    ch_force[0] = 1'b0;
    step(0, 0, 0, 3'b000, 3'b000, 3'b000);
    chk(pwm_out[0] == 1'b0, "R4 force 0", pwm_out[0], 0);

    // R7: active-high exhaustive sweep
    ch_en[0] = 1'b1; pair_mode = 2'd2;
    for (int k = 0; k < 8; k++) begin
      wr(0, k);
      for (int c = 0; c < 9; c++) begin
        step(c, 0, 0, 3'b001, 3'b000, 3'b000);
        chk(pwm_out[0] == (c > k), "R7 active-high level", pwm_out[0], (c > k));
        chk(match_irq[0] == (c == k), "R3 irq in level mode", match_irq[0], (c == k));
      end
    end
    step(0, 0, 0, 3'b000, 3'b000, 3'b000);
    chk(pwm_out[0] == 1'b1, "R7 holds without tick", pwm_out[0], 1);
    wr(0, 4);
    for (int c = 8; c >= 0; c--) begin
      step(c, 0, 0, 3'b001, 3'b000, 3'b000);
      chk(pwm_out[0] == (c > 4), "R7 falling count", pwm_out[0], (c > 4));
    end

    // R8: active-low exhaustive sweep
    pair_mode = 2'd3;
    for (int k = 0; k < 8; k++) begin
      wr(0, k);
      for (int c = 0; c < 9; c++) begin
        step(c, 0, 0, 3'b001, 3'b000, 3'b000);
        chk(pwm_out[0] == (c <= k), "R8 active-low level", pwm_out[0], (c <= k));
      end
    end

    // R6: set/clear mode
    pair_mode = 2'd1; ch_en = 2'b11;
    wr(0, 2); wr(1, 6);
    step(0, 0, 0, 3'b001, 3'b000, 3'b000);
    exp0 = pwm_out[0]; exp1 = pwm_out[1];
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 10; c++) begin
        step(c, 0, 0, 3'b001, 3'b000, 3'b000);
        if (c == 6) begin exp0 = 1'b0; exp1 = ~exp1; end
        else if (c == 2) exp0 = 1'b1;
        chk(pwm_out[0] == exp0, "R6 set/clear level", pwm_out[0], exp0);
        chk(pwm_out[1] == exp1, "R6 odd output toggles", pwm_out[1], exp1);
        chk(match_irq[1] == (c == 6), "R3 odd irq", match_irq[1], (c == 6));
      end
    end
    wr(1, 9);
    step(2, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(pwm_out[0] == 1'b1, "R6 set", pwm_out[0], 1);
    wr(0, 4); wr(1, 4);
    step(4, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(pwm_out[0] == 1'b0, "R6 clear wins", pwm_out[0], 0);
    chk(match_irq == 2'b11, "R3 both irqs", match_irq, 3);

    // R10 and R11: buffered writes and transfer points
    pair_mode = 2'd0; ch_en = 2'b01;
    wr(0, 7);
    buf_en[0] = 1'b1; xfer_peak[0] = 1'b0;
    wr(0, 3);
    step(3, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b0, "R10 shadow not yet active", match_irq[0], 0);
    step(7, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b1, "R10 old value still active", match_irq[0], 1);
    step(0, 0, 0, 3'b001, 3'b000, 3'b001);
    step(3, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b0, "R11 peak ignored in zero mode", match_irq[0], 0);
    step(0, 0, 0, 3'b000, 3'b001, 3'b000);
    step(3, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b0, "R11 zero without tick ignored", match_irq[0], 0);
    step(0, 0, 0, 3'b001, 3'b001, 3'b000);
    step(3, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b1, "R11 transfer at zero", match_irq[0], 1);
    xfer_peak[0] = 1'b1;
    wr(0, 6);
    step(0, 0, 0, 3'b001, 3'b001, 3'b000);
    step(6, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b0, "R11 zero ignored in peak mode", match_irq[0], 0);
    step(9, 0, 0, 3'b001, 3'b000, 3'b001);
    step(6, 0, 0, 3'b001, 3'b000, 3'b000);
    chk(match_irq[0] == 1'b1, "R11 transfer at peak", match_irq[0], 1);

    summary();
  end

endmodule